// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer/Counter

This block is a 16-bit up-counter peripheral for a microcontroller subsystem. Software reaches it through a byte-wide register bus with three address bits. Behind that bus are an 8-bit control register and two 16-bit compare/capture registers, A and B. Each of A and B holds a staging buffer and an active value. A value that software writes only reaches the active copy on the first count-source tick after the upper byte is written.

The counter advances on a selected count source. That source is one of three prescaler taps from the system clock (divide by 2048, 128 or 8) or an edge of the external event pin. One operating mode is chosen out of four:
- plain timer, which can also start on a trigger or count pin events;
- window counting, gated by the level of the pin;
- pulse-width measurement, which captures the count into B;
- programmable pulse generation (PPG), which toggles an output flip-flop on compare matches.

A single strobe output reports matches and captures. The event pin passes through a two-stage synchronizer. Everything runs in the single system clock domain, and the prescaler taps act as clock enables.

Register map:

| Address | Contents |
|---------|----------|
| 0 | control |
| 1 | A low byte |
| 2 | A high byte |
| 3 | B low byte |
| 4 | B high byte |
| 5 | live count, low byte |
| 6 | live count, high byte |

Reads of A and B return the active values.

Control register fields:

| Bits | Field | Meaning |
|------|-------|---------|
| [1:0] | run | 00 stop and clear, 01 start by command, 10 start on pin rising edge, 11 start on pin falling edge |
| [3:2] | source | 00 = /2048, 01 = /128, 10 = /8, 11 = event pin |
| [5:4] | mode | 00 timer/trigger/event, 01 window, 10 pulse width, 11 PPG |
| [6] | option | meaning depends on the mode |
| [7] | output init | initial output level |

Top module: `mm_timer16`

## Requirements
- R1: After reset the control register reads 0x00. A and B read 0xFFFF. The count reads 0. The output and the strobe are low.
- R2: While the run field is nonzero, a control write changes only bits [1:0]. Bits [7:2] keep their value.
- R3: A write to a high byte (address 2 or 4) is copied to the active register on the first count-source tick after that write. Until then, reads return the old value. Writing only a low byte never changes the active value.
- R4: A can be written in every mode. Writes to B are ignored unless the mode is PPG (11).
- R5: In timer mode with an internal source, each tick increments the count. A tick that finds count == A clears the count, toggles the output and pulses the strobe for one cycle. Matches are therefore (A+1) ticks apart, and source 10 gives one tick every 8 clocks.
- R6: With source 11 in timer mode, the count advances on pin rising edges when run is 01 or 10, and on pin falling edges when run is 11.
- R7: In window mode, internal ticks are counted only while the pin is high (run 01 or 10) or only while it is low (run 11).
- R8: In pulse-width mode, a capture edge copies the count into B, clears the count and pulses the strobe. With option=1 only one edge captures: falling when run is 01 or 10, rising when run is 11. With option=0 both edges capture.
- R9: In PPG mode, the output is loaded from bit 7 when the run field leaves 00. It then toggles on a tick where count == B (the count still advances) and again on a tick where count == A (the count clears and the strobe pulses).
- R10: In PPG mode with option=1, the counter stops after the A match. Further ticks change neither the count nor the output.
- R11: In timer mode with an internal source and run 10 or 11, counting waits for the selected pin edge. With option=1, the opposite edge stops the counter and clears the count.
- R12: In window mode with option=1, B tracks the running count. Once the gate closes, B equals the frozen count.
- R13: Writing run = 00 stops the counter and clears the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte (combinational from address) |
| ev_pin | input | 1 | External trigger/event/gate pin (asynchronous) |
| tmr_out | output | 1 | Timer output flip-flop |
| tmr_irq | output | 1 | One-cycle strobe on match or capture |

## Verification
The bench aims at the staging registers. It checks that a low-byte-only write never reaches the active value, that a high-byte write is invisible until the next pin tick, and that B stays untouched outside PPG mode. A design that committed on write, or on the low byte, would show the new value one read too early.

The bench also counts PPG output toggles exactly, pin edge by pin edge. It verifies that one-shot operation freezes both the count and the output after the A match, which a design that kept running would fail.

Capture edge selection, trigger start/stop and the control-register lock are each probed with a stimulus that gives a different count, strobe tally or readback when the wrong edge or field is honoured.

// File: rtl/tmr_pkg.sv
// Shared types and register map of the multi-mode timer.
// Assumes an 8-bit control register; field order is fixed by the struct below.
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_TIMER  = 2'b00,
        MODE_WINDOW = 2'b01,
        MODE_PULSE  = 2'b10,
        MODE_PPG    = 2'b11
    } tmr_mode_e;

    typedef enum logic [1:0] {
        RUN_STOP = 2'b00,
        RUN_CMD  = 2'b01,
        RUN_RISE = 2'b10,
        RUN_FALL = 2'b11
    } tmr_run_e;

    typedef struct packed {
        logic       ff_init;   // bit 7
        logic       opt;       // bit 6, mode dependent
        tmr_mode_e  mode;      // bits 5:4
        logic [1:0] clk_sel;   // bits 3:2
        tmr_run_e   run;       // bits 1:0
    } tmr_ctrl_t;

    localparam logic [1:0] CLK_PIN = 2'b11;

    localparam logic [2:0] ADR_CTRL   = 3'd0;
    localparam logic [2:0] ADR_A_LO   = 3'd1;
    localparam logic [2:0] ADR_A_HI   = 3'd2;
    localparam logic [2:0] ADR_B_LO   = 3'd3;
    localparam logic [2:0] ADR_B_HI   = 3'd4;
    localparam logic [2:0] ADR_CNT_LO = 3'd5;
    localparam logic [2:0] ADR_CNT_HI = 3'd6;

endpackage

// File: rtl/tmr_pinsync.sv
// Two-flop synchronizer and edge detector for the external event pin.
// Assumes the pin is asynchronous to clk; outputs are one-cycle edge pulses.
module tmr_pinsync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic sync1_q, sync2_q, prev_q;

    // Resynchronize the pin and keep one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= pin_i;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    assign level_o = sync2_q;
    assign rise_o  = sync2_q & ~prev_q;
    assign fall_o  = ~sync2_q & prev_q;

endmodule

// File: rtl/tmr_prescale.sv
// Free-running prescaler and count-source selector.
// Codes 0..2 pick a tap (one tick per 2^TAPn clocks); code 3 picks a pin edge.
// Assumes TAP0 is the largest tap and equals PRE_W.
module tmr_prescale #(
    parameter int PRE_W = 11,
    parameter int TAP0  = 11,
    parameter int TAP1  = 7,
    parameter int TAP2  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] clk_sel,
    input  logic       use_fall,
    input  logic       pin_rise,
    input  logic       pin_fall,
    output logic       tick_o
);
    localparam int NTAP = 3;

    logic [PRE_W-1:0] pre_q;
    logic [NTAP:0]    tap_tick;

    // Free-running divider that all taps are decoded from.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    for (genvar i = 0; i < NTAP; i++) begin : g_tap
        localparam int W = (i == 0) ? TAP0 : (i == 1) ? TAP1 : TAP2;
        assign tap_tick[i] = &pre_q[W-1:0];
    end
    assign tap_tick[NTAP] = 1'b0;

    // Pick the active count source.
    always_comb begin
        if (clk_sel == 2'b11) tick_o = use_fall ? pin_fall : pin_rise;
        else                  tick_o = tap_tick[clk_sel];
    end

    // The divide-by-8 tap never ticks in two consecutive cycles.
    assert_div8_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 2'b10 && $stable(clk_sel) && tick_o) |=> !tick_o);

endmodule

// File: rtl/tmr_dbuf.sv
// Staging buffer plus active register written one half-word at a time.
// The active value takes the staged pair on the first commit tick after the
// high half is written; a capture input overrides and loads it directly.
module tmr_dbuf #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [W/2-1:0] wdata,
    input  logic         commit,
    input  logic         cap_en,
    input  logic [W-1:0] cap_val,
    output logic [W-1:0] value_o
);
    localparam int HW = W / 2;

    logic [HW-1:0] lo_q, hi_q;
    logic          pend_q;

    // Stage written bytes, arm on high byte, move to active on tick or capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q    <= '1;
            hi_q    <= '1;
            pend_q  <= 1'b0;
            value_o <= '1;
        end else begin
            if (wr_lo) lo_q <= wdata;
            if (wr_hi) hi_q <= wdata;
            if (cap_en) begin
                value_o <= cap_val;
            end else if (commit && pend_q && !wr_hi) begin
                value_o <= {hi_q, lo_q};
            end
            if (wr_hi)                pend_q <= 1'b1;
            else if (commit && pend_q) pend_q <= 1'b0;
        end
    end

    // Without an armed high-byte write or a capture the active value holds.
    assert_no_commit_unarmed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_q && !cap_en) |=> $stable(value_o));

endmodule

// File: rtl/tmr_core.sv
// Counter, start/stop control, compare, capture and output flip-flop.
// Assumes tick and pin edges are single-cycle pulses in the clk domain.
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tmr_ctrl_t     ctrl,
    input  logic          tick,
    input  logic          pin_level,
    input  logic          pin_rise,
    input  logic          pin_fall,
    input  logic [CW-1:0] cmp_a,
    input  logic [CW-1:0] cmp_b,
    output logic [CW-1:0] count_o,
    output logic          out_o,
    output logic          irq_o,
    output logic          cap_en_o,
    output logic [CW-1:0] cap_val_o
);
    tmr_run_e run_q;
    logic     running_q, done_q;
    logic     stopped, starting, trig_mode, trig_go, trig_halt;
    logic     gate_open, step, pw_cap, auto_cap, hit_a, hit_b;

    // Decode start conditions, gating, capture events and compare hits.
    always_comb begin
        stopped   = (ctrl.run == RUN_STOP);
        starting  = (run_q == RUN_STOP) && !stopped;
        trig_mode = ctrl.run[1] && ((ctrl.mode == MODE_PPG) ||
                    (ctrl.mode == MODE_TIMER && ctrl.clk_sel != CLK_PIN));
        trig_go   = (ctrl.run == RUN_RISE) ? pin_rise : pin_fall;
        trig_halt = (ctrl.run == RUN_RISE) ? pin_fall : pin_rise;
        gate_open = (ctrl.mode != MODE_WINDOW) || (pin_level == (ctrl.run != RUN_FALL));
        step      = running_q && tick && gate_open;
        pw_cap    = running_q && (ctrl.mode == MODE_PULSE) &&
                    (ctrl.opt ? ((ctrl.run == RUN_FALL) ? pin_rise : pin_fall)
                              : (pin_rise | pin_fall));
        auto_cap  = running_q && (ctrl.mode == MODE_WINDOW) && ctrl.opt;
        hit_a     = (count_o == cmp_a);
        hit_b     = (count_o == cmp_b);
        cap_en_o  = pw_cap || auto_cap;
        cap_val_o = count_o;
    end

    // Run state, counter, output flip-flop and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= RUN_STOP;
            running_q <= 1'b0;
            done_q    <= 1'b0;
            count_o   <= '0;
            out_o     <= 1'b0;
            irq_o     <= 1'b0;
        end else begin
            run_q <= ctrl.run;
            irq_o <= 1'b0;
            if (stopped) begin
                running_q <= 1'b0;
                done_q    <= 1'b0;
                count_o   <= '0;
            end else begin
                if (starting) out_o <= ctrl.ff_init;
                if (!running_q) begin
                    if (trig_mode ? trig_go : !done_q) running_q <= 1'b1;
                end else if (ctrl.mode == MODE_TIMER && trig_mode && ctrl.opt && trig_halt) begin
                    running_q <= 1'b0;
                    count_o   <= '0;
                end else if (ctrl.mode == MODE_PULSE) begin
                    if (pw_cap) begin
                        count_o <= '0;
                        irq_o   <= 1'b1;
                    end else if (step) begin
                        count_o <= count_o + 1'b1;
                    end
                end else if (step) begin
                    if (hit_a) begin
                        count_o <= '0;
                        irq_o   <= 1'b1;
                        out_o   <= ~out_o;
                        if (ctrl.mode == MODE_PPG && ctrl.opt) begin
                            running_q <= 1'b0;
                            done_q    <= 1'b1;
                        end
                    end else begin
                        if (ctrl.mode == MODE_PPG && hit_b) out_o <= ~out_o;
                        count_o <= count_o + 1'b1;
                    end
                end
            end
        end
    end

    // Stop clears the count one cycle later.
    assert_stop_clears_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.run == RUN_STOP) |=> (count_o == '0));

    // An idle (not yet started or halted) counter keeps its value.
    assert_idle_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_q && ctrl.run != RUN_STOP) |=> $stable(count_o));

    // A pulse-width capture leaves the counter at zero.
    assert_capture_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pw_cap |=> (count_o == '0));

endmodule

// File: rtl/mm_timer16.sv
// Top of the multi-mode timer: register bus decode, control register with
// run-time lock, two staged compare/capture registers, prescaler, pin
// synchronizer and counter core. Assumes CW/2 >= 8 (control fits one byte).
module mm_timer16
    import tmr_pkg::*;
#(
    parameter int CW    = 16,
    parameter int PRE_W = 11,
    parameter int TAP0  = 11,
    parameter int TAP1  = 7,
    parameter int TAP2  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [2:0]         reg_addr,
    input  logic [CW/2-1:0]    reg_wdata,
    output logic [CW/2-1:0]    reg_rdata,
    input  logic               ev_pin,
    output logic               tmr_out,
    output logic               tmr_irq
);
    localparam int HW = CW / 2;

    tmr_ctrl_t     ctrl_q;
    logic          pin_lvl, pin_rise, pin_fall, tick;
    logic          b_wr_ok, cap_en;
    logic [CW-1:0] a_val, b_val, count, cap_val;

    // Control register: full write only while stopped, else run field only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (reg_we && reg_addr == ADR_CTRL) begin
            if (ctrl_q.run == RUN_STOP) ctrl_q     <= tmr_ctrl_t'(reg_wdata[7:0]);
            else                        ctrl_q.run <= tmr_run_e'(reg_wdata[1:0]);
        end
    end

    assign b_wr_ok = (ctrl_q.mode == MODE_PPG);

    // Read-back multiplexer.
    always_comb begin
        case (reg_addr)
            ADR_CTRL:   reg_rdata = HW'(ctrl_q);
            ADR_A_LO:   reg_rdata = a_val[HW-1:0];
            ADR_A_HI:   reg_rdata = a_val[CW-1:HW];
            ADR_B_LO:   reg_rdata = b_val[HW-1:0];
            ADR_B_HI:   reg_rdata = b_val[CW-1:HW];
            ADR_CNT_LO: reg_rdata = count[HW-1:0];
            ADR_CNT_HI: reg_rdata = count[CW-1:HW];
            default:    reg_rdata = '0;
        endcase
    end

    tmr_pinsync u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(ev_pin),
        .level_o(pin_lvl), .rise_o(pin_rise), .fall_o(pin_fall)
    );

    tmr_prescale #(.PRE_W(PRE_W), .TAP0(TAP0), .TAP1(TAP1), .TAP2(TAP2)) u_pre (
        .clk(clk), .rst_n(rst_n), .clk_sel(ctrl_q.clk_sel),
        .use_fall(ctrl_q.run == RUN_FALL),
        .pin_rise(pin_rise), .pin_fall(pin_fall), .tick_o(tick)
    );

    tmr_dbuf #(.W(CW)) u_reg_a (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(reg_we && reg_addr == ADR_A_LO),
        .wr_hi(reg_we && reg_addr == ADR_A_HI),
        .wdata(reg_wdata), .commit(tick),
        .cap_en(1'b0), .cap_val('0), .value_o(a_val)
    );

    tmr_dbuf #(.W(CW)) u_reg_b (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(reg_we && b_wr_ok && reg_addr == ADR_B_LO),
        .wr_hi(reg_we && b_wr_ok && reg_addr == ADR_B_HI),
        .wdata(reg_wdata), .commit(tick),
        .cap_en(cap_en), .cap_val(cap_val), .value_o(b_val)
    );

    tmr_core #(.CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .tick(tick),
        .pin_level(pin_lvl), .pin_rise(pin_rise), .pin_fall(pin_fall),
        .cmp_a(a_val), .cmp_b(b_val), .count_o(count),
        .out_o(tmr_out), .irq_o(tmr_irq), .cap_en_o(cap_en), .cap_val_o(cap_val)
    );

    // Configuration fields cannot move while the timer is running.
    assert_ctrl_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADR_CTRL && ctrl_q.run != RUN_STOP)
        |=> $stable(ctrl_q[7:2]));

endmodule

// File: tb/tb_mm_timer16.sv
// Directed bench for mm_timer16: one task per scenario, each checks itself.
module tb_mm_timer16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       ev_pin = 1'b0;
    logic       tmr_out, tmr_irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int irq_seen = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) begin
        cyc++;
        if (tmr_irq) irq_seen++;
    end

    mm_timer16 dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_pin(ev_pin),
        .tmr_out(tmr_out), .tmr_irq(tmr_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd8(input logic [2:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1 v = int'(reg_rdata);
    endtask

    task automatic rd16(input logic [2:0] lo_a, output int v);
        int lo, hi;
        rd8(lo_a, lo);
        rd8(lo_a + 3'd1, hi);
        v = (hi << 8) | lo;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_pin();
        @(negedge clk); ev_pin = 1'b1;
        idle(4);
        ev_pin = 1'b0;
        idle(4);
    endtask

    task automatic t_reset();
        int v;
        rd8(3'd0, v);  chk("R1 ctrl", v, 8'h00);
        rd16(3'd1, v); chk("R1 A", v, 16'hFFFF);
        rd16(3'd3, v); chk("R1 B", v, 16'hFFFF);
        rd16(3'd5, v); chk("R1 count", v, 0);
        chk("R1 out", int'(tmr_out), 0);
        chk("R1 irq", int'(tmr_irq), 0);
    endtask

    task automatic t_event();
        int v;
        wr(3'd0, 8'h0D);                 // timer mode, pin source, run 01
        repeat (5) pulse_pin();
        rd16(3'd5, v); chk("R6 rising edge count", v, 5);
        wr(3'd0, 8'h3E);                 // try to change mode while running
        rd8(3'd0, v);  chk("R2 ctrl lock", v, 8'h0E);
        wr(3'd0, 8'h00);
        idle(2);
        rd16(3'd5, v); chk("R13 stop clears", v, 0);
        wr(3'd0, 8'h0F);                 // run 11: falling edges
        repeat (3) pulse_pin();
        rd16(3'd5, v); chk("R6 falling edge count", v, 3);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_timer();
        int t1, t2, v;
        wr(3'd0, 8'h08);                 // /8 source, stopped
        wr(3'd1, 8'd9); wr(3'd2, 8'd0);
        idle(20);
        wr(3'd0, 8'h09);
        @(negedge clk); while (!tmr_irq) @(negedge clk);
        t1 = cyc;
        @(negedge clk); while (!tmr_irq) @(negedge clk);
        t2 = cyc;
        chk("R5 match period (A+1)*8", t2 - t1, 80);
        rd16(3'd5, v); chk_rng("R5 count cleared on match", v, 0, 1);
        wr(3'd0, 8'h08);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_window();
        int v, v2;
        wr(3'd0, 8'h18);                 // window, /8, stopped
        wr(3'd1, 8'hE8); wr(3'd2, 8'h03);// A = 1000
        idle(20);
        ev_pin = 1'b0;
        wr(3'd0, 8'h19);
        idle(100);
        rd16(3'd5, v); chk("R7 gate closed (pin low, positive)", v, 0);
        ev_pin = 1'b1; idle(160); ev_pin = 1'b0; idle(10);
        rd16(3'd5, v); chk_rng("R7 positive gate ticks", v, 19, 21);
        wr(3'd0, 8'h18); wr(3'd0, 8'h00);
        wr(3'd0, 8'h1B);                 // negative logic
        ev_pin = 1'b1;
        idle(100);
        rd16(3'd5, v); chk("R7 gate closed (pin high, negative)", v, 0);
        ev_pin = 1'b0; idle(80); ev_pin = 1'b1; idle(10);
        rd16(3'd5, v);
        idle(40);
        rd16(3'd5, v2);
        chk_rng("R7 negative gate ticks", v, 9, 11);
        chk("R7 frozen while high", v2, v);
        wr(3'd0, 8'h18); wr(3'd0, 8'h00);
        ev_pin = 1'b0;
        wr(3'd0, 8'h59);                 // window + auto-capture
        ev_pin = 1'b1; idle(100); ev_pin = 1'b0; idle(10);
        rd16(3'd5, v); rd16(3'd3, v2);
        chk("R12 B equals frozen count", v2, v);
        chk_rng("R12 count advanced", v, 11, 14);
        wr(3'd0, 8'h58); wr(3'd0, 8'h00);
    endtask

    task automatic t_pulse();
        int v, base;
        ev_pin = 1'b0;
        wr(3'd0, 8'h68);                 // pulse mode, single edge, /8
        base = irq_seen;
        wr(3'd0, 8'h69);
        idle(40);
        ev_pin = 1'b1; idle(160); ev_pin = 1'b0; idle(10);
        chk("R8 single edge one capture", irq_seen - base, 1);
        rd16(3'd5, v); chk_rng("R8 count cleared by capture", v, 0, 2);
        rd16(3'd3, v); chk_rng("R8 single capture value", v, 23, 27);
        wr(3'd0, 8'h68); wr(3'd0, 8'h00);
        wr(3'd0, 8'h28);                 // double edge
        base = irq_seen;
        wr(3'd0, 8'h29);
        idle(40);
        ev_pin = 1'b1; idle(160); ev_pin = 1'b0; idle(10);
        chk("R8 double edge two captures", irq_seen - base, 2);
        rd16(3'd3, v); chk_rng("R8 high width captured", v, 19, 21);
        wr(3'd0, 8'h28); wr(3'd0, 8'h00);
    endtask

    task automatic t_trigger();
        int v, v2;
        ev_pin = 1'b0;
        wr(3'd0, 8'h0A);                 // timer, /8, rising-edge start; A=1000
        idle(100);
        rd16(3'd5, v); chk("R11 waits for trigger", v, 0);
        ev_pin = 1'b1; idle(80);
        rd16(3'd5, v); chk_rng("R11 started on rise", v, 8, 11);
        ev_pin = 1'b0; idle(80);
        rd16(3'd5, v2); chk_rng("R11 start-only keeps running", v2, v + 9, v + 11);
        wr(3'd0, 8'h08); wr(3'd0, 8'h00);
        wr(3'd0, 8'h4A);                 // trigger start and stop
        ev_pin = 1'b1; idle(80);
        rd16(3'd5, v); chk_rng("R11 start/stop running", v, 8, 11);
        ev_pin = 1'b0; idle(80);
        rd16(3'd5, v); chk("R11 opposite edge stops and clears", v, 0);
        wr(3'd0, 8'h48); wr(3'd0, 8'h00);
    endtask

    task automatic t_ppg();
        int v, base;
        wr(3'd0, 8'h3C);                 // PPG, pin source, stopped
        wr(3'd1, 8'd5); wr(3'd2, 8'd0);
        wr(3'd3, 8'd2); wr(3'd4, 8'd0);
        pulse_pin();
        rd16(3'd1, v); chk("R3 A committed on tick", v, 5);
        rd16(3'd3, v); chk("R4 B written in PPG", v, 2);
        base = irq_seen;
        wr(3'd0, 8'h3D);                 // continuous, init level 0
        idle(2);
        chk("R9 initial level 0", int'(tmr_out), 0);
        repeat (3) pulse_pin();
        chk("R9 toggle on B match", int'(tmr_out), 1);
        repeat (3) pulse_pin();
        chk("R9 toggle on A match", int'(tmr_out), 0);
        rd16(3'd5, v); chk("R9 count cleared on A", v, 0);
        chk("R9 strobe on A match", irq_seen - base, 1);
        repeat (3) pulse_pin();
        chk("R9 continuous second cycle", int'(tmr_out), 1);
        wr(3'd0, 8'h3C);
        wr(3'd1, 8'd7);                  // low byte only
        pulse_pin();
        rd16(3'd1, v); chk("R3 low byte alone no commit", v, 5);
        wr(3'd2, 8'd0);
        rd16(3'd1, v); chk("R3 no commit before tick", v, 5);
        pulse_pin();
        rd16(3'd1, v); chk("R3 commit after tick", v, 7);
        base = irq_seen;
        wr(3'd0, 8'hFD);                 // one-shot, init level 1
        idle(2);
        chk("R9 initial level 1", int'(tmr_out), 1);
        repeat (3) pulse_pin();
        chk("R10 B toggle in one-shot", int'(tmr_out), 0);
        repeat (5) pulse_pin();
        chk("R10 A toggle in one-shot", int'(tmr_out), 1);
        repeat (4) pulse_pin();
        rd16(3'd5, v); chk("R10 count held after one-shot", v, 0);
        chk("R10 output held after one-shot", int'(tmr_out), 1);
        chk("R10 single strobe", irq_seen - base, 1);
        wr(3'd0, 8'h00);
        wr(3'd0, 8'h0C);                 // timer mode, pin source, stopped
        wr(3'd3, 8'h34); wr(3'd4, 8'h12);
        pulse_pin();
        rd16(3'd3, v); chk("R4 B ignored outside PPG", v, 2);
        wr(3'd1, 8'h21); wr(3'd2, 8'h00);
        pulse_pin();
        rd16(3'd1, v); chk("R4 A written in timer mode", v, 16'h0021);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_event();
        t_timer();
        t_window();
        t_pulse();
        t_trigger();
        t_ppg();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule